// File: doc/BRIEF.md
# Li-Ion Charge Sequencing Controller

This block is the digital sequencer of a single-cell lithium-ion charger. The analog front end supplies digitized comparator flags: the input-supply window checks, the adaptor-above-battery check, the battery voltage against its qualification, regulation and restart levels, the end-of-charge current check, the temperature window, the LDO-mode detect and the enable input. The block walks the cell through trickle pre-qualification, constant-current fast charge, constant-voltage taper and a maintenance watch. It then tells the regulation loop which current setpoint to use and whether to regulate voltage.

A safety timer counts prescaled ticks only while in constant-current phase. It faults the charge if the cell fails to reach regulation voltage in time. A temperature excursion suspends charging. When the temperature returns to range, the flow restarts at pre-qualification with the timer cleared. Two active-low indicator outputs report the state: red for a first charge, green for end of charge and for enable-off, and both for a fault. All flag inputs are asynchronous and pass through two-flop synchronizers. The tick input comes from the same clock domain. The reset is asynchronous on assertion and is expected to be released synchronously by the chip reset logic.

Top module: `chg_seq_ctrl`

## Requirements
- R1: While reset is held and right after it, phase_o is 0 (off), red_n_o and grn_n_o are 1, vreg_en_o is 0 and iset_sel_o is 0.
- R2: Every flag input passes through two flip-flops, so a flag change driven between clock edges first changes phase_o at the third rising edge after it.
- R3: From off, with supply valid (uv_ok_i, ov_ok_i and adp_ok_i all 1), en_i 1 and ldo_det_i 0, the phase becomes pre-qualification (1) if temp_ok_i is 1 and suspended (5) otherwise.
- R4: Pre-qualification moves to constant-current (2) when bat_qual_i is 1. iset_sel_o is 1 and iset_code_o equals prog_code_i only in phases 2 and 3. Otherwise iset_code_o is the PRE_CODE parameter.
- R5: Constant-current moves to constant-voltage (3) when bat_reg_i is 1. vreg_en_o is 1 in phases 3 and 8 only.
- R6: The safety timer counts ticks only in phase 2 and clears in every other phase. When TIMER_TICKS ticks have been counted in phase 2, the next phase is fault (6), which takes priority over bat_reg_i.
- R7: Constant-voltage moves to maintenance (4) when i_low_i is 1.
- R8: Maintenance moves to pre-qualification when bat_rst_i is 1. From then until supply is lost, the charging phases 1 to 3 show green instead of red.
- R9: A temp_ok_i of 0 in phase 1, 2 or 3 moves to suspended (5). A return to 1 moves to pre-qualification with the timer restarted from zero.
- R10: Loss of any supply flag returns the phase to off from any phase, with highest priority.
- R11: With supply valid, en_i 0 gives phase 7 (disabled) from any phase, and en_i back to 1 gives off. Fault holds until supply loss, disable or LDO detect.
- R12: With supply valid and en_i 1, ldo_det_i 1 gives phase 8 (LDO), and its clearing gives off.
- R13: Indicators (red_n_o, grn_n_o) are: phases 0 and 8 give 1,1. Phases 1 to 3 give 0,1 on a first charge and 1,0 on a recharge. Phases 4 and 7 give 1,0. Phases 5 and 6 give 0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_ok_i | input | 1 | Supply above undervoltage trip |
| ov_ok_i | input | 1 | Supply below overvoltage trip |
| adp_ok_i | input | 1 | Supply sufficiently above battery |
| bat_qual_i | input | 1 | Battery above fast-charge qualification level |
| bat_reg_i | input | 1 | Battery at regulation voltage |
| i_low_i | input | 1 | Charge current below end-of-charge level |
| bat_rst_i | input | 1 | Battery below restart level |
| temp_ok_i | input | 1 | Battery temperature inside window |
| ldo_det_i | input | 1 | Temperature sense near bias rail (LDO mode) |
| en_i | input | 1 | Charger enable |
| tick_i | input | 1 | Prescaled timer tick, one-cycle pulse, same clock domain |
| prog_code_i | input | CODE_W | Programmed fast-charge current code |
| phase_o | output | 4 | Active phase code |
| iset_sel_o | output | 1 | 1 selects programmed current, 0 precharge current |
| iset_code_o | output | CODE_W | Current setpoint code in use |
| vreg_en_o | output | 1 | Voltage regulation enable |
| red_n_o | output | 1 | Charging indicator, active low |
| grn_n_o | output | 1 | End-of-charge indicator, active low |

## Verification
The bench checks the timer window at both ends. Just under TIMER_TICKS ticks the phase must still be constant-current, and a timer that fired early or counted outside that phase would fault there. After a temperature suspension it re-runs the full window, so a timer that kept its count across the restart would fault too soon. The bench also checks the exact edge at which a flag takes effect, which a synchronizer with the wrong depth would miss. It checks that a fault is held while bat_reg_i rises, so a design that let regulation override the fault would move on. It covers the red-to-green swap after a recharge and its clearing on supply loss, which an indicator decoder without the recharge history would get wrong.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [3:0] {
    PH_OFF   = 4'd0,
    PH_PREQ  = 4'd1,
    PH_CC    = 4'd2,
    PH_CV    = 4'd3,
    PH_MAINT = 4'd4,
    PH_SUSP  = 4'd5,
    PH_FAULT = 4'd6,
    PH_DIS   = 4'd7,
    PH_LDO   = 4'd8
  } phase_e;

  // flag vector bit positions
  localparam int FL_UV   = 0;
  localparam int FL_OV   = 1;
  localparam int FL_ADP  = 2;
  localparam int FL_QUAL = 3;
  localparam int FL_REG  = 4;
  localparam int FL_ILOW = 5;
  localparam int FL_RST  = 6;
  localparam int FL_TEMP = 7;
  localparam int FL_LDO  = 8;
  localparam int FL_EN   = 9;
  localparam int NFLAGS  = 10;
endpackage

// File: rtl/chg_flag_sync.sv
module chg_flag_sync #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [DEPTH-1:0] stg_q;
    logic [DEPTH-1:0] stg_d;
    always_comb begin
      stg_d = {stg_q[DEPTH-2:0], d_i[b]};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= stg_d;
    end
    assign q_o[b] = stg_q[DEPTH-1];
  end
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer #(
  parameter int TIMER_TICKS = 20160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CW = $clog2(TIMER_TICKS + 1);
  localparam logic [CW-1:0] TERM = CW'(TIMER_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !run_i || (tick_i && (cnt_q != TERM));
    if (!run_i) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == TERM);
endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
  import chg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_ok_i,
  input  logic   en_i,
  input  logic   ldo_i,
  input  logic   temp_ok_i,
  input  logic   qual_i,
  input  logic   reg_i,
  input  logic   ilow_i,
  input  logic   rst_lvl_i,
  input  logic   tmr_exp_i,
  output phase_e phase_o,
  output logic   recharge_o
);
  phase_e st_q, st_d;
  logic   rch_q, rch_d;

  always_comb begin
    st_d  = st_q;
    rch_d = rch_q;
    if (!pwr_ok_i) begin
      st_d  = PH_OFF;
      rch_d = 1'b0;
    end else if (!en_i) begin
      st_d = PH_DIS;
    end else if (ldo_i) begin
      st_d = PH_LDO;
    end else begin
      case (st_q)
        PH_OFF:   st_d = temp_ok_i ? PH_PREQ : PH_SUSP;
        PH_PREQ:  if (!temp_ok_i) st_d = PH_SUSP;
                  else if (qual_i) st_d = PH_CC;
        PH_CC:    if (!temp_ok_i) st_d = PH_SUSP;
                  else if (tmr_exp_i) st_d = PH_FAULT;
                  else if (reg_i) st_d = PH_CV;
        PH_CV:    if (!temp_ok_i) st_d = PH_SUSP;
                  else if (ilow_i) st_d = PH_MAINT;
        PH_MAINT: if (rst_lvl_i) begin
                    st_d  = PH_PREQ;
                    rch_d = 1'b1;
                  end
        PH_SUSP:  if (temp_ok_i) st_d = PH_PREQ;
        PH_FAULT: st_d = PH_FAULT;
        PH_DIS:   st_d = PH_OFF;
        PH_LDO:   st_d = PH_OFF;
        default:  st_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_OFF;
      rch_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rch_q <= rch_d;
    end
  end

  assign phase_o    = st_q;
  assign recharge_o = rch_q;

  // R10
  pwr_loss_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok_i |=> (st_q == PH_OFF && !rch_q));

  // R6
  timeout_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_CC && tmr_exp_i && pwr_ok_i && en_i && !ldo_i && temp_ok_i)
      |=> (st_q == PH_FAULT));

  // R6
  timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PH_CC) |=> !tmr_exp_i);

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_FAULT && pwr_ok_i && en_i && !ldo_i) |=> (st_q == PH_FAULT));

  // R4
  no_skip_preq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {PH_CC, PH_CV, PH_FAULT, PH_DIS, PH_LDO}) |=> (st_q != PH_PREQ));
endmodule

// File: rtl/chg_status_enc.sv
module chg_status_enc
  import chg_pkg::*;
(
  input  phase_e phase_i,
  input  logic   recharge_i,
  output logic   iset_sel_o,
  output logic   vreg_en_o,
  output logic   red_n_o,
  output logic   grn_n_o
);
  always_comb begin
    iset_sel_o = (phase_i == PH_CC) || (phase_i == PH_CV);
    vreg_en_o  = (phase_i == PH_CV) || (phase_i == PH_LDO);
    red_n_o    = 1'b1;
    grn_n_o    = 1'b1;
    case (phase_i)
      PH_PREQ, PH_CC, PH_CV: begin
        red_n_o = recharge_i;
        grn_n_o = !recharge_i;
      end
      PH_MAINT, PH_DIS: grn_n_o = 1'b0;
      PH_SUSP, PH_FAULT: begin
        red_n_o = 1'b0;
        grn_n_o = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
  import chg_pkg::*;
#(
  parameter int          CODE_W      = 4,
  parameter int          TIMER_TICKS = 20160,
  parameter int          SYNC_DEPTH  = 2,
  parameter logic [CODE_W-1:0] PRE_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_ok_i,
  input  logic              ov_ok_i,
  input  logic              adp_ok_i,
  input  logic              bat_qual_i,
  input  logic              bat_reg_i,
  input  logic              i_low_i,
  input  logic              bat_rst_i,
  input  logic              temp_ok_i,
  input  logic              ldo_det_i,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] prog_code_i,
  output logic [3:0]        phase_o,
  output logic              iset_sel_o,
  output logic [CODE_W-1:0] iset_code_o,
  output logic              vreg_en_o,
  output logic              red_n_o,
  output logic              grn_n_o
);
  logic [NFLAGS-1:0] raw, syn;
  phase_e            phase;
  logic              recharge, tmr_exp, pwr_ok;

  always_comb begin
    raw          = '0;
    raw[FL_UV]   = uv_ok_i;
    raw[FL_OV]   = ov_ok_i;
    raw[FL_ADP]  = adp_ok_i;
    raw[FL_QUAL] = bat_qual_i;
    raw[FL_REG]  = bat_reg_i;
    raw[FL_ILOW] = i_low_i;
    raw[FL_RST]  = bat_rst_i;
    raw[FL_TEMP] = temp_ok_i;
    raw[FL_LDO]  = ldo_det_i;
    raw[FL_EN]   = en_i;
  end

  chg_flag_sync #(.W(NFLAGS), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  assign pwr_ok = syn[FL_UV] & syn[FL_OV] & syn[FL_ADP];

  chg_safety_timer #(.TIMER_TICKS(TIMER_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(phase == PH_CC), .tick_i(tick_i),
    .expired_o(tmr_exp)
  );

  chg_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .en_i(syn[FL_EN]),
    .ldo_i(syn[FL_LDO]), .temp_ok_i(syn[FL_TEMP]), .qual_i(syn[FL_QUAL]),
    .reg_i(syn[FL_REG]), .ilow_i(syn[FL_ILOW]), .rst_lvl_i(syn[FL_RST]),
    .tmr_exp_i(tmr_exp), .phase_o(phase), .recharge_o(recharge)
  );

  chg_status_enc u_enc (
    .phase_i(phase), .recharge_i(recharge), .iset_sel_o(iset_sel_o),
    .vreg_en_o(vreg_en_o), .red_n_o(red_n_o), .grn_n_o(grn_n_o)
  );

  assign phase_o     = phase;
  assign iset_code_o = iset_sel_o ? prog_code_i : PRE_CODE;
endmodule

// File: tb/tb_chg_seq_ctrl.sv
module tb_chg_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam logic [3:0] PRE = 4'hF;

  logic clk = 1'b0;
  logic rst_n;
  logic uv, ov, adp, qual, rg, ilow, brst, temp, ldo, en, tick, tick_en;
  logic [3:0] prog;
  logic [3:0] phase;
  logic sel, vreg, red_n, grn_n;
  logic [3:0] code;

  int n_tests = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_seq_ctrl #(.CODE_W(4), .TIMER_TICKS(NT), .PRE_CODE(PRE)) dut (
    .clk(clk), .rst_n(rst_n), .uv_ok_i(uv), .ov_ok_i(ov), .adp_ok_i(adp),
    .bat_qual_i(qual), .bat_reg_i(rg), .i_low_i(ilow), .bat_rst_i(brst),
    .temp_ok_i(temp), .ldo_det_i(ldo), .en_i(en), .tick_i(tick),
    .prog_code_i(prog), .phase_o(phase), .iset_sel_o(sel), .iset_code_o(code),
    .vreg_en_o(vreg), .red_n_o(red_n), .grn_n_o(grn_n)
  );

  task automatic chk(input int got, input int exp, input string tag);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic go(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // tick generator: one-cycle pulse every other cycle when enabled
  always @(negedge clk) begin
    #1;
    tick = tick_en && !tick;
  end

  // behavioural reference model
  int m_st, m_cnt, nst;
  bit m_rch;
  bit s1 [10];
  bit s2 [10];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_rch = 0;
      foreach (s1[i]) begin s1[i] = 0; s2[i] = 0; end
    end else begin
      bit p_ok;
      int ncnt;
      p_ok = s2[0] && s2[1] && s2[2];
      nst = m_st;
      if (!p_ok) begin nst = 0; m_rch = 0; end
      else if (!s2[9]) nst = 7;
      else if (s2[8]) nst = 8;
      else if (m_st == 0) nst = s2[7] ? 1 : 5;
      else if (m_st >= 1 && m_st <= 3 && !s2[7]) nst = 5;
      else if (m_st == 1 && s2[3]) nst = 2;
      else if (m_st == 2 && m_cnt >= NT) nst = 6;
      else if (m_st == 2 && s2[4]) nst = 3;
      else if (m_st == 3 && s2[5]) nst = 4;
      else if (m_st == 4 && s2[6]) begin nst = 1; m_rch = 1; end
      else if (m_st == 5 && s2[7]) nst = 1;
      else if (m_st == 7 || m_st == 8) nst = 0;
      ncnt = (m_st == 2) ? ((tick && m_cnt < NT) ? m_cnt + 1 : m_cnt) : 0;
      foreach (s2[i]) s2[i] = s1[i];
      s1[0] = uv; s1[1] = ov; s1[2] = adp; s1[3] = qual; s1[4] = rg;
      s1[5] = ilow; s1[6] = brst; s1[7] = temp; s1[8] = ldo; s1[9] = en;
      m_st = nst; m_cnt = ncnt;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d cycles", cyc, 20000);
      done();
    end
    if (rst_n) begin
      int er, eg;
      bit chg;
      chg = (m_st >= 1 && m_st <= 3);
      er = 1; eg = 1;
      if (chg) begin er = m_rch ? 1 : 0; eg = m_rch ? 0 : 1; end
      else if (m_st == 4 || m_st == 7) eg = 0;
      else if (m_st == 5 || m_st == 6) begin er = 0; eg = 0; end
      chk(phase, m_st, "R2 phase vs model");
      chk(red_n, er, "R13 red vs model");
      chk(grn_n, eg, "R13 green vs model");
      chk(vreg, (m_st == 3 || m_st == 8), "R5 vreg vs model");
      chk(sel, (m_st == 2 || m_st == 3), "R4 select vs model");
      chk(code, (m_st == 2 || m_st == 3) ? prog : PRE, "R4 code vs model");
    end
  end

  initial begin
    rst_n = 0; tick = 0; tick_en = 0;
    uv = 0; ov = 0; adp = 0; qual = 0; rg = 0; ilow = 0; brst = 0;
    temp = 0; ldo = 0; en = 0; prog = 4'h8;
    go(3);
    chk(phase, 0, "R1 phase in reset");
    chk(red_n, 1, "R1 red in reset");
    chk(grn_n, 1, "R1 green in reset");
    #1 rst_n = 1;
    go(1);
    chk(vreg, 0, "R1 vreg after reset");
    chk(sel, 0, "R1 select after reset");
    // power with bad temperature
    #1 uv = 1; ov = 1; adp = 1; en = 1;
    go(4);
    chk(phase, 5, "R3 start into suspend");
    chk(red_n + grn_n, 0, "R13 both on when suspended");
    #1 temp = 1;
    go(4);
    chk(phase, 1, "R3 prequal");
    chk(red_n, 0, "R13 red on first charge");
    chk(code, PRE, "R4 precharge code");
    #1 qual = 1;
    go(4);
    chk(phase, 2, "R4 fast charge");
    chk(code, 8, "R4 programmed code");
    #1 rg = 1;
    go(2);
    chk(phase, 2, "R2 not before third edge");
    go(1);
    chk(phase, 3, "R5 constant voltage on third edge");
    chk(vreg, 1, "R5 vreg in CV");
    #1 ilow = 1;
    go(4);
    chk(phase, 4, "R7 maintenance");
    chk(grn_n, 0, "R13 green in maintenance");
    #1 ilow = 0; rg = 0; qual = 0; brst = 1;
    go(3);
    chk(phase, 1, "R8 restart to prequal");
    chk(grn_n, 0, "R8 green on recharge");
    chk(red_n, 1, "R8 red off on recharge");
    #1 brst = 0; qual = 1;
    go(4);
    chk(phase, 2, "R8 back to fast charge");
    #1 tick_en = 1;
    go(12);
    chk(phase, 2, "R6 no early timeout");
    go(10);
    chk(phase, 6, "R6 timeout fault");
    #1 rg = 1;
    go(4);
    chk(phase, 6, "R11 fault holds");
    chk(red_n + grn_n, 0, "R13 both on in fault");
    #1 en = 0;
    go(4);
    chk(phase, 7, "R11 disabled");
    chk(grn_n, 0, "R11 green when disabled");
    #1 en = 1;
    go(6);
    chk(phase, 3, "R11 restart after enable");
    #1 uv = 0; rg = 0; tick_en = 0;
    go(4);
    chk(phase, 0, "R10 supply loss");
    #1 uv = 1;
    go(5);
    chk(phase, 2, "R10 fresh charge");
    chk(red_n, 0, "R13 red after reinsertion");
    #1 tick_en = 1;
    go(10);
    #1 tick_en = 0;
    go(1);
    #1 temp = 0;
    go(4);
    chk(phase, 5, "R9 temperature suspend");
    #1 temp = 1;
    go(5);
    chk(phase, 2, "R9 resume");
    #1 tick_en = 1;
    go(12);
    chk(phase, 2, "R9 timer cleared on resume");
    go(10);
    chk(phase, 6, "R9 full window after resume");
    #1 tick_en = 0; ldo = 1;
    go(4);
    chk(phase, 8, "R12 LDO phase");
    chk(red_n + grn_n, 2, "R12 indicators off");
    chk(vreg, 1, "R12 vreg in LDO");
    #1 ldo = 0;
    go(3);
    chk(phase, 0, "R12 leave LDO to off");
    go(3);
    #1 adp = 0;
    go(3);
    chk(phase, 0, "R10 adaptor loss");
    go(2);
    done();
  end
endmodule